// File: doc/BRIEF.md
# Cascadable LCD Segment Data Latch

This block collects one display line for a bank of LCD segment outputs and holds it steady while the next line is gathered. Display data arrives as 4-bit beats on a valid/ready stream. Each accepted beat writes four adjacent positions of a line latch. A direction input picks the fill order: from the lowest output upward, or from the highest output downward. The block starts each line from its first position again after every load pulse.

Several copies can share one data stream. Each copy has two enable pins that form a chain between neighbours. The enable is active low, and only one device at a time accepts beats. When a device has taken a complete line, it drives its enable output low, which selects the next device in the chain. The chain pins are brought out as separate input, output and output-enable signals, and the direction input decides which pin drives.

A load pulse copies the whole line latch into the output latch in one cycle. The output latch is combined with a frame polarity input and an active-low blanking input. The result is a 2-bit drive-level code for every output, which an analog driver outside this block turns into voltages.

Top module: `lcdseg_latch`

## Requirements
- R1: A beat is taken on a rising clock edge where `din_valid` and `din_ready` are both high. `din_ready` is high only when the selected enable input is low, the line is not yet complete, and `load` is low. A valid beat with `din_ready` low stays with the sender; nothing is dropped and nothing is written.
- R2: With `dir_up` high, beat k (counting from 0 after reset or a load) writes `din[j]` to output index 4k+j, so outputs 0..3 are filled first.
- R3: With `dir_up` low, beat k writes `din[j]` to output index NUM_OUT-1-4k-j, so the first beat's bit 0 lands on the highest output.
- R4: With `dir_up` low, chain pin A drives (`chain_a_oe`=1) and pin B is the enable input. With `dir_up` high, pin B drives (`chain_b_oe`=1) and pin A is the enable input.
- R5: The enable output (`chain_a_o` and `chain_b_o` carry the same value) is high until the NUM_OUT/4-th beat of a line is taken. It is low from the next cycle on, and `din_ready` is low from that cycle until a load.
- R6: A cycle with `load` high copies the line latch into the output latch at that clock edge. It returns the enable output high and restarts the fill at beat 0 for the next line.
- R7: While the selected enable input is high, offered beats have no effect. `din_ready` stays low, and the line latch keeps its contents, as a following load shows.
- R8: With `blank_n` high, each output's code depends on its latched bit b and on `pol`: b=1, pol=0 gives 00 (V1); b=0, pol=0 gives 01 (V3); b=0, pol=1 gives 10 (V4); b=1, pol=1 gives 11 (VEE). Output i uses `levels[2i+1:2i]`.
- R9: With `blank_n` low, every output code is 00, whatever the data or polarity.
- R10: Reset clears the output latch, the line latch and the beat count. After reset the enable output is high and, with `pol` low and `blank_n` high, every code is 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dir_up | input | 1 | Fill direction: 1 fills upward from output 0, 0 fills downward from the top output |
| din_valid | input | 1 | A display-data beat is offered |
| din_ready | output | 1 | The block takes the offered beat this cycle |
| din | input | 4 | Four display bits; bit j goes to the j-th position of the beat |
| load | input | 1 | Line transfer strobe, one cycle wide |
| pol | input | 1 | Frame polarity for AC inversion |
| blank_n | input | 1 | Active-low blanking: low forces every output to code 00 |
| chain_a_i | input | 1 | Chain pin A, input value |
| chain_a_o | output | 1 | Chain pin A, driven value (active-low enable) |
| chain_a_oe | output | 1 | Chain pin A drives when high |
| chain_b_i | input | 1 | Chain pin B, input value |
| chain_b_o | output | 1 | Chain pin B, driven value (active-low enable) |
| chain_b_oe | output | 1 | Chain pin B drives when high |
| levels | output | 2*NUM_OUT | Drive-level code per output, two bits each |

## Verification
A wrong beat count shows in two ways. The enable output falls one beat early or late, and `din_ready` drops at the wrong place in the line. Both are visible within the same line, and the bench samples them beat by beat. A wrong write index puts data on the wrong outputs, but that shows only after the next load, when the whole 320-bit code vector is compared against a model built from the requirement's index formula. A wrong polarity or blanking term changes the code in the same cycle, because the encoding after the output latch has no register.

// File: rtl/lcdseg_pkg.sv
package lcdseg_pkg;

  // Drive-level codes handed to the analog stage.
  typedef enum logic [1:0] {
    LVL_V1  = 2'b00,
    LVL_V3  = 2'b01,
    LVL_V4  = 2'b10,
    LVL_VEE = 2'b11
  } lvl_e;

  // Level for one latched bit under the given frame polarity.
  function automatic lvl_e lvl_code(input logic bit_q, input logic pol);
    lvl_e r;
    case ({pol, bit_q})
      2'b00:   r = LVL_V3;
      2'b01:   r = LVL_V1;
      2'b10:   r = LVL_V4;
      default: r = LVL_VEE;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/lcdseg_token.sv
// Beat counter and enable-chain pin routing.
module lcdseg_token #(
  parameter int BEATS = 40,
  localparam int CNT_W = $clog2(BEATS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_up,
  input  logic             chain_a_i,
  input  logic             chain_b_i,
  input  logic             load,
  input  logic             beat,
  output logic             sel_n,
  output logic             line_full,
  output logic [CNT_W-1:0] count,
  output logic             chain_a_o,
  output logic             chain_a_oe,
  output logic             chain_b_o,
  output logic             chain_b_oe
);

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (load) begin
      count_q <= '0;
    end else if (beat) begin
      count_q <= count_q + 1'b1;
    end
  end

  assign count     = count_q;
  assign line_full = (count_q == CNT_W'(BEATS));

  // Upward fill takes its enable on pin A; downward fill on pin B.
  assign sel_n      = dir_up ? chain_a_i : chain_b_i;
  assign chain_a_o  = ~line_full;
  assign chain_b_o  = ~line_full;
  assign chain_a_oe = ~dir_up;
  assign chain_b_oe = dir_up;

endmodule

// File: rtl/lcdseg_line.sv
// Line latch written four positions per beat in either direction.
module lcdseg_line #(
  parameter int NUM_OUT = 160,
  parameter int BEAT_W  = 4,
  localparam int BEATS = NUM_OUT / BEAT_W,
  localparam int CNT_W = $clog2(BEATS + 1),
  localparam int IDX_W = $clog2(NUM_OUT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dir_up,
  input  logic               beat,
  input  logic [BEAT_W-1:0]  din,
  input  logic [CNT_W-1:0]   count,
  output logic [NUM_OUT-1:0] line
);

  logic [IDX_W-1:0] base;
  logic [IDX_W-1:0] wr_idx [BEAT_W];
  logic [NUM_OUT-1:0] line_q;

  assign base = IDX_W'(count) * IDX_W'(BEAT_W);

  for (genvar j = 0; j < BEAT_W; j++) begin : g_idx
    assign wr_idx[j] = dir_up ? (base + IDX_W'(j))
                              : (IDX_W'(NUM_OUT - 1 - j) - base);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
    end else if (beat) begin
      for (int j = 0; j < BEAT_W; j++) begin
        line_q[wr_idx[j]] <= din[j];
      end
    end
  end

  assign line = line_q;

endmodule

// File: rtl/lcdseg_level.sv
// Output latch and per-output level encoding.
module lcdseg_level #(
  parameter int NUM_OUT = 160
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [NUM_OUT-1:0]   line,
  input  logic                 pol,
  input  logic                 blank_n,
  output logic [2*NUM_OUT-1:0] levels
);
  import lcdseg_pkg::*;

  logic [NUM_OUT-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (load) begin
      hold_q <= line;
    end
  end

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_enc
    assign levels[2*i +: 2] = blank_n ? lvl_code(hold_q[i], pol) : LVL_V1;
  end

endmodule

// File: rtl/lcdseg_latch.sv
module lcdseg_latch #(
  parameter int NUM_OUT = 160,
  parameter int BEAT_W  = 4,
  localparam int BEATS = NUM_OUT / BEAT_W,
  localparam int CNT_W = $clog2(BEATS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dir_up,
  input  logic                 din_valid,
  output logic                 din_ready,
  input  logic [BEAT_W-1:0]    din,
  input  logic                 load,
  input  logic                 pol,
  input  logic                 blank_n,
  input  logic                 chain_a_i,
  output logic                 chain_a_o,
  output logic                 chain_a_oe,
  input  logic                 chain_b_i,
  output logic                 chain_b_o,
  output logic                 chain_b_oe,
  output logic [2*NUM_OUT-1:0] levels
);

  logic               sel_n;
  logic               line_full;
  logic               beat;
  logic [CNT_W-1:0]   count;
  logic [NUM_OUT-1:0] line;

  assign din_ready = ~sel_n & ~line_full & ~load;
  assign beat      = din_valid & din_ready;

  lcdseg_token #(.BEATS(BEATS)) u_token (
    .clk(clk), .rst_n(rst_n), .dir_up(dir_up),
    .chain_a_i(chain_a_i), .chain_b_i(chain_b_i),
    .load(load), .beat(beat), .sel_n(sel_n), .line_full(line_full),
    .count(count),
    .chain_a_o(chain_a_o), .chain_a_oe(chain_a_oe),
    .chain_b_o(chain_b_o), .chain_b_oe(chain_b_oe)
  );

  lcdseg_line #(.NUM_OUT(NUM_OUT), .BEAT_W(BEAT_W)) u_line (
    .clk(clk), .rst_n(rst_n), .dir_up(dir_up), .beat(beat),
    .din(din), .count(count), .line(line)
  );

  lcdseg_level #(.NUM_OUT(NUM_OUT)) u_level (
    .clk(clk), .rst_n(rst_n), .load(load), .line(line),
    .pol(pol), .blank_n(blank_n), .levels(levels)
  );

endmodule

// File: rtl/lcdseg_latch_chk.sv
module lcdseg_latch_chk #(
  parameter int NUM_OUT = 160,
  parameter int BEAT_W  = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 dir_up,
  input logic                 din_valid,
  input logic                 din_ready,
  input logic [BEAT_W-1:0]    din,
  input logic                 load,
  input logic                 pol,
  input logic                 blank_n,
  input logic                 chain_a_i,
  input logic                 chain_a_o,
  input logic                 chain_a_oe,
  input logic                 chain_b_i,
  input logic                 chain_b_o,
  input logic                 chain_b_oe,
  input logic [2*NUM_OUT-1:0] levels
);

  // R7
  ignore_when_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((dir_up ? chain_a_i : chain_b_i) == 1'b1) |-> !din_ready);

  // R1
  no_take_during_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !din_ready);

  // R6
  token_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (chain_a_o && chain_b_o));

  // R5
  token_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chain_a_o) |-> $past(din_valid && din_ready));

  // R9
  blank_all_v1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_n |-> (levels == '0));

  // R6
  levels_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load) && $stable(pol) && $stable(blank_n)) |-> $stable(levels));

  // R4
  one_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({chain_a_oe, chain_b_oe}));

endmodule

bind lcdseg_latch lcdseg_latch_chk #(.NUM_OUT(NUM_OUT), .BEAT_W(BEAT_W)) u_chk (.*);

// File: tb/lcdseg_latch_bench.sv
module lcdseg_latch_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 160;
  localparam int BEATS = N / 4;

  // Row layout: [10] dir_up, [9] pol, [8] blank_n, [7:0] seed
  localparam logic [10:0] ROWS [6] = '{
    {1'b1, 1'b0, 1'b1, 8'h11},
    {1'b0, 1'b0, 1'b1, 8'h2A},
    {1'b1, 1'b1, 1'b1, 8'h37},
    {1'b0, 1'b1, 1'b1, 8'h4C},
    {1'b1, 1'b0, 1'b0, 8'h55},
    {1'b0, 1'b1, 1'b1, 8'h63}
  };

  logic clk = 0, rst_n = 0;
  logic dir_up = 0, din_valid = 0, load = 0, pol = 0, blank_n = 1;
  logic [3:0] din = 0;
  logic en_n = 0;
  logic din_ready, chain_a_o, chain_a_oe, chain_b_o, chain_b_oe;
  logic [2*N-1:0] levels;
  logic [N-1:0] exp_line = '0;
  logic [N-1:0] exp_hold = '0;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcdseg_latch u_lcdseg_latch (
    .clk(clk), .rst_n(rst_n), .dir_up(dir_up), .din_valid(din_valid),
    .din_ready(din_ready), .din(din), .load(load), .pol(pol),
    .blank_n(blank_n), .chain_a_i(en_n), .chain_a_o(chain_a_o),
    .chain_a_oe(chain_a_oe), .chain_b_i(en_n), .chain_b_o(chain_b_o),
    .chain_b_oe(chain_b_oe), .levels(levels)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [2*N-1:0] act, input logic [2*N-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] code(input logic b, input logic p, input logic bl);
    if (!bl) return 2'b00;
    if (!p)  return b ? 2'b00 : 2'b01;
    return b ? 2'b11 : 2'b10;
  endfunction

  function automatic logic [2*N-1:0] exp_levels(input logic [N-1:0] h,
                                                input logic p, input logic bl);
    logic [2*N-1:0] r;
    for (int i = 0; i < N; i++) r[2*i +: 2] = code(h[i], p, bl);
    return r;
  endfunction

  function automatic logic [3:0] pat(input logic [7:0] seed, input int k);
    return 4'(seed * 7 + k * 5 + (k >> 2));
  endfunction

  // Offer one beat for one cycle; record it in the model if it will be taken.
  task automatic send(input logic [3:0] d, input bit model_it);
    @(negedge clk);
    din = d; din_valid = 1;
    if (model_it) begin
      for (int j = 0; j < 4; j++) begin
        if (dir_up) exp_line[4*u_k + j] = d[j];
        else        exp_line[N-1-4*u_k-j] = d[j];
      end
      u_k++;
    end
    @(negedge clk);
    din_valid = 0;
  endtask
  int u_k = 0;

  task automatic pulse_load();
    @(negedge clk);
    load = 1;
    @(negedge clk);
    load = 0;
    exp_hold = exp_line;
    u_k = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk(levels == exp_levels('0, 1'b0, 1'b1), "R10 levels", levels, exp_levels('0, 1'b0, 1'b1));
    chk(chain_a_o && chain_b_o, "R10 enable out", {chain_a_o, chain_b_o}, 2'b11);
    chk(din_ready == 1'b1, "R10 ready", din_ready, 1'b1);
    // R4 pin roles
    chk({chain_a_oe, chain_b_oe} == 2'b10, "R4 dir low", {chain_a_oe, chain_b_oe}, 2'b10);
    dir_up = 1; #1;
    chk({chain_a_oe, chain_b_oe} == 2'b01, "R4 dir high", {chain_a_oe, chain_b_oe}, 2'b01);

    // Table walk: R2 R3 R6 R8 R9
    for (int r = 0; r < 6; r++) begin
      dir_up = ROWS[r][10];
      for (int k = 0; k < BEATS; k++) send(pat(ROWS[r][7:0], k), 1);
      pulse_load();
      pol = ROWS[r][9]; blank_n = ROWS[r][8]; #1;
      chk(levels == exp_levels(exp_hold, pol, blank_n),
          ROWS[r][8] ? (ROWS[r][10] ? "R2 R8 up fill" : "R3 R8 down fill") : "R9 blank",
          levels, exp_levels(exp_hold, pol, blank_n));
    end
    pol = 0; blank_n = 1;

    // R5 token timing and ready drop
    dir_up = 1;
    for (int k = 0; k < BEATS - 1; k++) send(4'(k), 1);
    chk(chain_a_o == 1'b1, "R5 before last beat", chain_a_o, 1'b1);
    send(4'hF, 1);
    chk(chain_a_o == 1'b0 && chain_b_o == 1'b0, "R5 after last beat", {chain_a_o, chain_b_o}, 2'b00);
    chk(din_ready == 1'b0, "R5 ready low when full", din_ready, 1'b0);
    send(4'h0, 0);  // refused: line already full
    @(negedge clk);
    din_valid = 1; load = 1; #1;
    // R1 load blocks acceptance
    chk(din_ready == 1'b0, "R1 ready low during load", din_ready, 1'b0);
    @(negedge clk);
    din_valid = 0; load = 0;
    exp_hold = exp_line; u_k = 0;
    chk(chain_a_o == 1'b1, "R6 enable released", chain_a_o, 1'b1);
    chk(levels == exp_levels(exp_hold, 1'b0, 1'b1), "R6 copy on load",
        levels, exp_levels(exp_hold, 1'b0, 1'b1));

    // R7 deselected device ignores beats
    en_n = 1;
    #1;
    chk(din_ready == 1'b0, "R7 ready low when deselected", din_ready, 1'b0);
    for (int k = 0; k < 6; k++) send(4'(~k), 0);
    pulse_load();
    chk(levels == exp_levels(exp_hold, 1'b0, 1'b1), "R7 line unchanged",
        levels, exp_levels(exp_hold, 1'b0, 1'b1));
    chk(chain_a_o == 1'b1, "R7 enable out still high", chain_a_o, 1'b1);
    en_n = 0;

    // R1 partial line then restart after load: first beat lands at beat 0
    dir_up = 0;
    send(4'b1010, 1);
    send(4'b0110, 1);
    pulse_load();
    pol = 1; #1;
    chk(levels == exp_levels(exp_hold, 1'b1, 1'b1), "R1 R3 partial line",
        levels, exp_levels(exp_hold, 1'b1, 1'b1));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule